// File: doc/BRIEF.md
# Programmable PWM Ramp Sequencer

This block drives one pulse-width-modulated output from a tiny instruction engine. A free-running 8-bit counter advances on every base-rate tick, which is a clock enable (nominally 32768 Hz) and not a second clock. The output is high while the current brightness level is at or above the counter value. The brightness level is not written directly. It is produced by a short program of 16-bit words. The program can force the level fully on or fully off, ramp it up or down one unit per step at a chosen step time, and branch back to its first word.

The host loads the program through a byte-wide write strobe while the channel is disabled. Each word takes two writes, high byte first and then low byte, and the words fill consecutive slots starting from slot 0. When the channel is enabled, execution starts at slot 0 and the level keeps its last value. When the channel is disabled, execution halts, the output goes low and the load pointer returns to slot 0.

Top module: `pwm_ramp_seq`

## Requirements
- R1: The 8-bit counter increments, wrapping modulo 256, on each clock where `tick` is high and is otherwise held. `pwm_out` equals `chan_en` AND (level >= counter), so a level of L gives L+1 high counts per 256-count period.
- R2: While `chan_en` is low, each pair of `wr_stb` bytes forms one word, with the first byte as bits 15:8 and the second as bits 7:0. Successive words go to slots 0, 1, 2 and so on. Strobes while `chan_en` is high are ignored.
- R3: After 64 words have been loaded, further strobes are ignored until the channel is next enabled and disabled.
- R4: While `chan_en` is low, `pwm_out` is low, execution stops, the program counter returns to 0 and the level is held. After enable, execution starts at slot 0 with the level unchanged.
- R5: Word 0x007F sets the level to 0x00 and word 0x00FF sets it to 0xFF. Each takes one clock and moves on to the next slot.
- R6: A word with bit 15 = 0, a step time T = bits 13:8 that is non-zero, and a step count N = bits 6:0 that is non-zero is a ramp. It moves the level by one unit (up if bit 7 = 0, down if bit 7 = 1) each T step ticks, N times, and then moves on.
- R7: In a ramp, bit 14 = 0 makes every base tick a step tick. Bit 14 = 1 makes every 512th base tick (counted from ramp start) a step tick.
- R8: Ramps saturate at 0x00 and 0xFF instead of wrapping.
- R9: A word with bits 15 and 13 both set is a branch and sets the program counter to slot 0.
- R10: The all-zero word, and any word that is not one of the kinds above, is a one-clock no-op. After the last loaded slot (or slot 63), the program counter wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel run enable; low allows program loading |
| wr_stb | input | 1 | Program byte write strobe, one byte per clock |
| wr_data | input | 8 | Program byte |
| tick | input | 1 | Base-rate clock enable for the counter and ramp stepping |
| pwm_out | output | 1 | PWM output |

## Verification
On every cycle, the in-module assertions check the following: the counter only steps on a tick, the level moves by at most one unit except on a set instruction, the level stays pinned at its limits during ramps, the level holds while the channel is disabled, the load pointer stays bounded, and the program counter stays inside the loaded program. Only the bench scenarios can show the instruction encodings taking effect. This covers the prescaled step timing, branch and wrap ordering, rejected writes (while enabled or past 64 words) leaving the program intact, and the high-time per counter period matching the level. The bench observes these through `pwm_out` against a behavioural cycle model.

// File: rtl/pwm_ramp_pkg.sv
package pwm_ramp_pkg;

  localparam int LVL_W  = 8;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_SET_OFF,
    OP_SET_ON,
    OP_RAMP,
    OP_BRANCH
  } op_e;

  typedef struct packed {
    logic       pre;
    logic [5:0] stime;
    logic       down;
    logic [6:0] steps;
  } ramp_f_t;

  function automatic op_e decode_op(input logic [WORD_W-1:0] w);
    if (w[15] && w[13])                              return OP_BRANCH;
    else if (w == 16'h007F)                          return OP_SET_OFF;
    else if (w == 16'h00FF)                          return OP_SET_ON;
    else if (!w[15] && (w[13:8] != 6'd0) && (w[6:0] != 7'd0)) return OP_RAMP;
    else                                             return OP_NOP;
  endfunction

  function automatic ramp_f_t ramp_fields(input logic [WORD_W-1:0] w);
    ramp_f_t f;
    f.pre   = w[14];
    f.stime = w[13:8];
    f.down  = w[7];
    f.steps = w[6:0];
    return f;
  endfunction

  function automatic logic [LVL_W-1:0] sat_step(input logic [LVL_W-1:0] lvl,
                                                input logic down);
    if (down) return (lvl == '0) ? '0 : lvl - 1'b1;
    else      return (lvl == '1) ? '1 : lvl + 1'b1;
  endfunction

endpackage

// File: rtl/pwm_prog_mem.sv
module pwm_prog_mem
  import pwm_ramp_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              wr_stb,
  input  logic [7:0]        wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_word,
  output logic [PW-1:0]     prog_len
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_ptr;
  logic [7:0]        hi_byte;
  logic              hi_valid;
  logic              full;
  logic              word_commit;

  assign full        = (wr_ptr == PW'(DEPTH));
  assign word_commit = load_en && wr_stb && !full && hi_valid;
  assign rd_word     = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      hi_valid <= 1'b0;
      hi_byte  <= '0;
      prog_len <= '0;
    end else if (!load_en) begin
      wr_ptr   <= '0;
      hi_valid <= 1'b0;
    end else if (wr_stb && !full) begin
      if (!hi_valid) begin
        hi_byte  <= wr_data;
        hi_valid <= 1'b1;
      end else begin
        wr_ptr   <= wr_ptr + PW'(1);
        prog_len <= wr_ptr + PW'(1);
        hi_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (word_commit) begin
      mem[wr_ptr[AW-1:0]] <= {hi_byte, wr_data};
    end
  end

  a_r3_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= PW'(DEPTH));

  a_r3_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (full && load_en) |=> (wr_ptr == PW'(DEPTH)));

  a_r2_len_frozen_running: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> (prog_len == $past(prog_len)));

endmodule

// File: rtl/pwm_seq_engine.sv
module pwm_seq_engine
  import pwm_ramp_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int PRESCALE = 512,
  localparam int AW  = $clog2(DEPTH),
  localparam int PW  = $clog2(DEPTH + 1),
  localparam int PSW = $clog2(PRESCALE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [WORD_W-1:0] word,
  input  logic [PW-1:0]     prog_len,
  output logic [AW-1:0]     pc,
  output logic [LVL_W-1:0]  level
);

  op_e           op;
  ramp_f_t       fld;
  logic          have_prog;
  logic          at_end;
  logic [AW-1:0] pc_adv;
  logic          in_ramp;
  logic [6:0]    steps_left;
  logic [5:0]    time_left;
  logic [5:0]    stime_r;
  logic          pre_r;
  logic          down_r;
  logic [PSW-1:0] pre_cnt;
  logic          pre_wrap;
  logic          step_tick;
  logic          step_evt;
  logic          set_evt;

  assign op        = decode_op(word);
  assign fld       = ramp_fields(word);
  assign have_prog = (prog_len != '0);
  assign at_end    = (pc == AW'(DEPTH - 1)) || ((PW'(pc) + PW'(1)) == prog_len);
  assign pc_adv    = at_end ? '0 : pc + AW'(1);
  assign pre_wrap  = (pre_cnt == PSW'(PRESCALE - 1));
  assign step_tick = tick && (!pre_r || pre_wrap);
  assign step_evt  = run && in_ramp && step_tick && (time_left == 6'd1);
  assign set_evt   = run && !in_ramp && have_prog &&
                     ((op == OP_SET_OFF) || (op == OP_SET_ON));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc         <= '0;
      level      <= '0;
      in_ramp    <= 1'b0;
      steps_left <= '0;
      time_left  <= '0;
      stime_r    <= '0;
      pre_r      <= 1'b0;
      down_r     <= 1'b0;
      pre_cnt    <= '0;
    end else if (!run) begin
      pc      <= '0;
      in_ramp <= 1'b0;
    end else if (in_ramp) begin
      if (tick && pre_r) pre_cnt <= pre_wrap ? '0 : pre_cnt + PSW'(1);
      if (step_tick) begin
        if (time_left == 6'd1) begin
          level     <= sat_step(level, down_r);
          time_left <= stime_r;
          if (steps_left == 7'd1) begin
            in_ramp <= 1'b0;
            pc      <= pc_adv;
          end else begin
            steps_left <= steps_left - 7'd1;
          end
        end else begin
          time_left <= time_left - 6'd1;
        end
      end
    end else if (have_prog) begin
      case (op)
        OP_BRANCH:  pc <= '0;
        OP_SET_OFF: begin level <= '0; pc <= pc_adv; end
        OP_SET_ON:  begin level <= '1; pc <= pc_adv; end
        OP_RAMP: begin
          in_ramp    <= 1'b1;
          steps_left <= fld.steps;
          time_left  <= fld.stime;
          stime_r    <= fld.stime;
          pre_r      <= fld.pre;
          down_r     <= fld.down;
          pre_cnt    <= '0;
        end
        default:    pc <= pc_adv;
      endcase
    end
  end

  a_r8_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !down_r && level == '1) |=> (level == '1));

  a_r8_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && down_r && level == '0) |=> (level == '0));

  a_r6_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !set_evt |=> ((level == $past(level)) ||
                  (level == $past(level) + 8'd1) ||
                  (level == $past(level) - 8'd1)));

  a_r4_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (level == $past(level)));

  a_r10_pc_in_program: assert property (@(posedge clk) disable iff (!rst_n)
    (run && have_prog) |-> (PW'(pc) < prog_len));

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
  import pwm_ramp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic [LVL_W-1:0] level,
  output logic             pwm_out
);

  logic [LVL_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt + LVL_W'(1);
  end

  assign pwm_out = enable && (level >= cnt);

  a_r1_cnt_advance: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == $past(cnt) + 8'd1));

  a_r1_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (cnt == $past(cnt)));

endmodule

// File: rtl/pwm_ramp_seq.sv
module pwm_ramp_seq
  import pwm_ramp_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int PRESCALE = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_en,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  input  logic       tick,
  output logic       pwm_out
);

  logic [AW-1:0]     pc;
  logic [WORD_W-1:0] cur_word;
  logic [PW-1:0]     prog_len;
  logic [LVL_W-1:0]  level;

  pwm_prog_mem #(.DEPTH(DEPTH)) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (!chan_en),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .rd_addr  (pc),
    .rd_word  (cur_word),
    .prog_len (prog_len)
  );

  pwm_seq_engine #(.DEPTH(DEPTH), .PRESCALE(PRESCALE)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (chan_en),
    .tick     (tick),
    .word     (cur_word),
    .prog_len (prog_len),
    .pc       (pc),
    .level    (level)
  );

  pwm_compare u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .enable  (chan_en),
    .level   (level),
    .pwm_out (pwm_out)
  );

endmodule

// File: tb/pwm_ramp_seq_tb.sv
module pwm_ramp_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       chan_en;
  logic       wr_stb;
  logic [7:0] wr_data;
  logic       tick;
  logic       pwm_out;

  int checks = 0;
  int fails  = 0;
  int tk_div = 1;
  bit done   = 0;

  always #2 clk = ~clk;

  pwm_ramp_seq u_dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wr_stb(wr_stb),
    .wr_data(wr_data), .tick(tick), .pwm_out(pwm_out)
  );

  // behavioural reference model
  int m_mem [64];
  int m_ptr, m_len, m_half, m_hi, m_cnt, m_lvl, m_pc;
  int m_ramp, m_sl, m_tl, m_st, m_ps, m_dn, m_pre;

  function automatic int nxt(int p, int l);
    return (p == 63 || p + 1 == l) ? 0 : p + 1;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) m_mem[i] = 0;
      m_ptr = 0; m_len = 0; m_half = 0; m_hi = 0; m_cnt = 0; m_lvl = 0;
      m_pc = 0; m_ramp = 0; m_sl = 0; m_tl = 0; m_st = 0; m_ps = 0;
      m_dn = 0; m_pre = 0;
    end else begin
      if (tick) m_cnt = (m_cnt + 1) % 256;
      if (chan_en) begin
        m_ptr = 0; m_half = 0;
      end else if (wr_stb && m_ptr < 64) begin
        if (!m_half) begin m_hi = wr_data; m_half = 1; end
        else begin
          m_mem[m_ptr] = m_hi * 256 + wr_data;
          m_ptr++; m_len = m_ptr; m_half = 0;
        end
      end
      if (!chan_en) begin
        m_pc = 0; m_ramp = 0;
      end else if (m_ramp) begin
        bit ptk;
        ptk = tick && (!m_ps || m_pre == 511);
        if (tick && m_ps) m_pre = (m_pre + 1) % 512;
        if (ptk) begin
          if (m_tl == 1) begin
            if (m_dn) m_lvl = (m_lvl > 0) ? m_lvl - 1 : 0;
            else      m_lvl = (m_lvl < 255) ? m_lvl + 1 : 255;
            m_tl = m_st;
            if (m_sl == 1) begin m_ramp = 0; m_pc = nxt(m_pc, m_len); end
            else m_sl--;
          end else m_tl--;
        end
      end else if (m_len > 0) begin
        int w;
        w = m_mem[m_pc];
        if ((w / 32768) % 2 == 1 && (w / 8192) % 2 == 1) m_pc = 0;
        else if (w == 127) begin m_lvl = 0; m_pc = nxt(m_pc, m_len); end
        else if (w == 255) begin m_lvl = 255; m_pc = nxt(m_pc, m_len); end
        else if (w < 32768 && (w / 256) % 64 != 0 && w % 128 != 0) begin
          m_sl = w % 128; m_tl = (w / 256) % 64; m_st = m_tl;
          m_ps = (w / 16384) % 2; m_dn = (w / 128) % 2; m_pre = 0; m_ramp = 1;
        end else m_pc = nxt(m_pc, m_len);
      end
    end
    #1;
    begin
      int exp_out;
      exp_out = (chan_en && m_lvl >= m_cnt) ? 1 : 0;
      if (rst_n) check(pwm_out == exp_out, "R1 per-cycle pwm_out", pwm_out, exp_out);
    end
  end

  // base tick generator
  initial begin
    int dc;
    dc = 0; tick = 0;
    forever begin
      @(negedge clk);
      if (dc + 1 >= tk_div) begin tick = 1; dc = 0; end
      else begin tick = 0; dc++; end
    end
  end

  task automatic put_byte(input int b);
    @(negedge clk); wr_stb = 1; wr_data = 8'(b);
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic put_word(input int w);
    put_byte(w / 256);
    put_byte(w % 256);
  endtask

  task automatic set_en(input bit v);
    @(negedge clk); chan_en = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // high counts over one full 256-tick period (requires tick every cycle)
  task automatic period_check(input string tag, input int exp);
    int hi;
    hi = 0;
    for (int i = 0; i < 256; i++) begin
      @(posedge clk); #1;
      if (pwm_out) hi++;
    end
    check(hi == exp, tag, hi, exp);
  endtask

  initial begin
    rst_n = 0; chan_en = 0; wr_stb = 0; wr_data = 0;
    idle(5);
    check(pwm_out == 0, "R1 reset output low", pwm_out, 0);
    @(negedge clk); rst_n = 1;
    idle(3);

    // set-on then branch: level 255
    put_word(16'h00FF); put_word(16'hA000);
    set_en(1); idle(8);
    period_check("R5 set-on high time", 256);

    // disable forces output low
    set_en(0); idle(2);
    check(pwm_out == 0, "R4 disabled output low", pwm_out, 0);

    // set-off; writes while enabled ignored
    put_word(16'h007F); put_word(16'hA000);
    set_en(1); idle(8);
    period_check("R5 set-off high time", 1);
    put_word(16'h00FF);
    idle(8);
    period_check("R2 write while running ignored", 1);

    // ramp up with step time 3 and slow ticks
    set_en(0);
    put_word(16'h007F); put_word(16'h0306); put_word(16'hA000);
    tk_div = 3; set_en(1); idle(300);
    set_en(0); tk_div = 1;
    put_word(16'h0000);
    set_en(1); idle(4);
    period_check("R6 level held after ramp", m_lvl + 1);
    period_check("R4 restart keeps level", m_lvl + 1);

    // saturation at top, wrap after last loaded word
    set_en(0);
    put_word(16'h00FF); put_word(16'h0105); put_word(16'h0000);
    set_en(1); idle(6);
    period_check("R8 top saturation", 256);
    period_check("R10 wrap without branch", 256);

    // saturation at bottom
    set_en(0);
    put_word(16'h007F); put_word(16'h0185);
    set_en(1); idle(6);
    period_check("R8 bottom saturation", 1);

    // ramp down with undefined word in loop
    set_en(0);
    put_word(16'h00FF); put_word(16'h0284); put_word(16'h0000); put_word(16'h8000);
    set_en(1); idle(200);

    // prescaled ramp: two steps of 512 ticks
    set_en(0);
    put_word(16'h007F);
    set_en(1); idle(4);
    set_en(0);
    put_word(16'h4102);
    set_en(1); idle(1100);
    set_en(0);
    put_word(16'h0000);
    set_en(1); idle(4);
    period_check("R7 prescaled ramp level", 3);

    // 64 words loaded, extra word ignored
    set_en(0);
    put_word(16'h007F);
    for (int i = 1; i < 64; i++) put_word(16'h0000);
    put_word(16'h00FF);
    set_en(1); idle(140);
    period_check("R3 overflow write ignored", 1);

    // branch taken before a later set-off
    set_en(0);
    put_word(16'h00FF); put_word(16'hA000); put_word(16'h007F);
    set_en(1); idle(8);
    period_check("R9 branch loops to start", 256);

    // undefined opcode and zero step time act as no-ops
    set_en(0);
    put_word(16'h007F); put_word(16'h8105); put_word(16'h0005);
    set_en(1); idle(20);
    period_check("R10 undefined words are no-ops", 1);

    set_en(0); idle(4);
    check(pwm_out == 0, "R4 final disable low", pwm_out, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule